// File: doc/BRIEF.md
# Address-Based Security Level Map

This block sits at the front of an external-memory security core. For every cache-line access it takes the address, reduces it to the base address of the line, and looks it up in a small table of memory segments. Each segment covers an inclusive address range and carries a segment identifier, a protection level and a read-only flag. The result drives the datapath controls of the core one clock later: whether the line is enciphered, whether its integrity tag is computed and checked, and whether a per-line time stamp is kept.

The segment table is set entirely by synthesis parameters. There is no write port, so running software cannot lower the protection of any region. When segments overlap, the entry with the lowest index takes priority. An address outside every segment is treated as unprotected and flagged as unmapped.

A confidentiality-only segment needs no time stamp. The downstream keystream logic sees the time-stamp enable low and feeds zeros in that field. A read-only segment at the full level is never rewritten, so it is not exposed to replay. It keeps integrity checking but also drops the time stamp.

Top module: `sec_level_map`

## Requirements
- R1: The lookup uses the cache-line base address: the low LINE_OFS_W address bits have no effect on any output.
- R2: The `level` output encodes the matched segment's protection as 0 = none, 1 = confidentiality only, 2 = confidentiality plus integrity.
- R3: `enc_en` is high exactly when the looked-up level is 1 or 2.
- R4: `ic_en` is high exactly when the looked-up level is 2.
- R5: `ts_en` is high only for a level-2 segment whose read-only flag is clear. It is low for level-1 segments, so the keystream time-stamp field is zero, and low for read-only segments.
- R6: `seg_id` carries the ID_W-bit identifier of the matched segment. The same value is returned for every line of that segment.
- R7: A segment matches when SEG_BASE <= line base <= SEG_LIMIT, with both ends included.
- R8: When several segments match, the one with the lowest index decides every output.
- R9: An address that matches no segment gives `unmapped` = 1, level 0, `seg_id` 0, and `enc_en`, `ic_en` and `ts_en` low.
- R10: The result of a request with `req_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. `out_valid` is low after an edge where `req_valid` was low.
- R11: While `out_valid` is low, `level`, `seg_id`, `enc_en`, `ic_en`, `ts_en` and `unmapped` are all zero.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access address is presented |
| req_addr | input | ADDR_W | Byte address of the access |
| out_valid | output | 1 | Lookup result valid |
| enc_en | output | 1 | Encipher or decipher the line |
| ic_en | output | 1 | Compute and check the integrity tag |
| ts_en | output | 1 | Use and update a per-line time stamp |
| seg_id | output | ID_W | Identifier of the matched segment |
| level | output | 2 | Protection level of the matched segment |
| unmapped | output | 1 | No segment matched the address |

## Verification
The bench uses the default parameters: 32-bit addresses, 32-byte lines and four segments. The table holds a read-only full-protection region, a writable full-protection region, a confidentiality-only region that overlaps the upper half of the second, and an unprotected region, with holes between them. This puts every level, the read-only exception, lowest-index priority and the unmapped default within reach of a few dozen addresses. Directed accesses hit the first and last byte of each range and the lines on either side of each boundary. A long run of random addresses over the whole span, with `req_valid` toggling, is then compared every clock against a behavioural lookup.

// File: rtl/sec_level_map.sv
module sec_level_map #(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS_W = 5,
  parameter int NSEG       = 4,
  parameter int ID_W       = 8,
  parameter logic [NSEG*ADDR_W-1:0] SEG_BASE  = {32'h0001_0000, 32'h0000_6000, 32'h0000_4000, 32'h0000_0000},
  parameter logic [NSEG*ADDR_W-1:0] SEG_LIMIT = {32'h0001_FFFF, 32'h0000_9FFF, 32'h0000_7FFF, 32'h0000_3FFF},
  parameter logic [NSEG*2-1:0]      SEG_LEVEL = {2'd0, 2'd1, 2'd2, 2'd2},
  parameter logic [NSEG*ID_W-1:0]   SEG_ID    = {8'd4, 8'd3, 8'd2, 8'd1},
  parameter logic [NSEG-1:0]        SEG_RO    = 4'b0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  output logic              enc_en,
  output logic              ic_en,
  output logic              ts_en,
  output logic [ID_W-1:0]   seg_id,
  output logic [1:0]        level,
  output logic              unmapped
);

  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-LINE_OFS_W){1'b1}}, {LINE_OFS_W{1'b0}}};

  logic [ADDR_W-1:0] line_base;
  logic [NSEG-1:0]   hit;
  logic              any_hit;
  logic [1:0]        sel_lvl;
  logic [ID_W-1:0]   sel_id;
  logic              sel_ro;

  assign line_base = req_addr & LINE_MASK;
  assign any_hit   = |hit;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign hit[i] = (line_base >= SEG_BASE[i*ADDR_W +: ADDR_W]) &&
                    (line_base <= SEG_LIMIT[i*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    sel_lvl = 2'd0;
    sel_id  = '0;
    sel_ro  = 1'b0;
    for (int i = NSEG-1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_lvl = SEG_LEVEL[i*2 +: 2];
        sel_id  = SEG_ID[i*ID_W +: ID_W];
        sel_ro  = SEG_RO[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      out_valid <= 1'b0;
      enc_en    <= 1'b0;
      ic_en     <= 1'b0;
      ts_en     <= 1'b0;
      seg_id    <= '0;
      level     <= 2'd0;
      unmapped  <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      enc_en    <= (sel_lvl != 2'd0);
      ic_en     <= (sel_lvl == 2'd2);
      ts_en     <= (sel_lvl == 2'd2) && !sel_ro;
      seg_id    <= sel_id;
      level     <= sel_lvl;
      unmapped  <= !any_hit;
    end
  end

  // R4
  ic_implies_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_en |-> enc_en);

  // R5
  ts_implies_ic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_en |-> (ic_en && level == 2'd2));

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (!enc_en && !ic_en && !ts_en && level == 2'd0 && seg_id == '0));

  // R10
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R10
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!enc_en && !ic_en && !ts_en && !unmapped && level == 2'd0 && seg_id == '0));

endmodule

// File: tb/sec_level_map_tb.sv
module sec_level_map_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        out_valid, enc_en, ic_en, ts_en, unmapped;
  logic [7:0]  seg_id;
  logic [1:0]  level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sec_level_map dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .out_valid(out_valid), .enc_en(enc_en), .ic_en(ic_en), .ts_en(ts_en),
    .seg_id(seg_id), .level(level), .unmapped(unmapped)
  );

  // Segment table as stated for the default build, index 0 first.
  int unsigned tb_lo [4] = '{32'h0, 32'h4000, 32'h6000, 32'h1_0000};
  int unsigned tb_hi [4] = '{32'h3FFF, 32'h7FFF, 32'h9FFF, 32'h1_FFFF};
  int          tb_lv [4] = '{2, 2, 1, 0};
  int          tb_id [4] = '{1, 2, 3, 4};
  bit          tb_ro [4] = '{1, 0, 0, 0};

  // expected fields, for the request registered at the last edge
  bit exp_v, exp_en, exp_ic, exp_ts, exp_un;
  int exp_lv, exp_id;

  task automatic model(input bit v, input int unsigned a);
    int unsigned base;
    int m;
    base = a & 32'hFFFF_FFE0;
    m = -1;
    for (int i = 3; i >= 0; i--)
      if (base >= tb_lo[i] && base <= tb_hi[i]) m = i;
    exp_v = v;
    if (!v) begin
      exp_en = 0; exp_ic = 0; exp_ts = 0; exp_un = 0; exp_lv = 0; exp_id = 0;
    end else if (m < 0) begin
      exp_en = 0; exp_ic = 0; exp_ts = 0; exp_un = 1; exp_lv = 0; exp_id = 0;
    end else begin
      exp_lv = tb_lv[m];
      exp_id = tb_id[m];
      exp_en = (exp_lv != 0);
      exp_ic = (exp_lv == 2);
      exp_ts = (exp_lv == 2) && !tb_ro[m];
      exp_un = 0;
    end
  endtask

  task automatic cmp(input string tag, input string f, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R10"}, "out_valid", int'(out_valid), int'(exp_v));
    cmp({tag, " R2"},  "level",     int'(level),     exp_lv);
    cmp({tag, " R3"},  "enc_en",    int'(enc_en),    int'(exp_en));
    cmp({tag, " R4"},  "ic_en",     int'(ic_en),     int'(exp_ic));
    cmp({tag, " R5"},  "ts_en",     int'(ts_en),     int'(exp_ts));
    cmp({tag, " R6"},  "seg_id",    int'(seg_id),    exp_id);
    cmp({tag, " R9"},  "unmapped",  int'(unmapped),  int'(exp_un));
  endtask

  string cur_tag = "R12 reset";

  // drive at negedge, result expected after next posedge, checked at following negedge
  task automatic step(input string tag, input bit v, input int unsigned a);
    @(negedge clk);
    check_all(cur_tag);
    req_valid = v;
    req_addr  = a;
    model(v, a);
    cur_tag = tag;
  endtask

  initial begin
    model(0, 0);
    repeat (3) begin
      @(negedge clk);
      check_all("R12 reset");
      req_valid = 1'b1;
      req_addr = 32'h4000;
    end
    @(negedge clk);
    check_all("R12 reset");
    rst_n = 1'b1;
    req_valid = 1'b0;
    model(0, 0);
    cur_tag = "R11 idle";
    step("R11 idle", 0, 32'h4000);
    // R1 low offset bits ignored within a line
    step("R1 line lo",  1, 32'h0000_4000);
    step("R1 line hi",  1, 32'h0000_401F);
    step("R1 line mid", 1, 32'h0000_3FFF);
    // R5 read-only segment: integrity without time stamp
    step("R5 ro seg",   1, 32'h0000_0100);
    // R7 inclusive range edges and neighbours
    step("R7 base0",    1, 32'h0000_0000);
    step("R7 lim0",     1, 32'h0000_3FE0);
    step("R7 lim1",     1, 32'h0000_7FFF);
    step("R7 lim2",     1, 32'h0000_9FFF);
    step("R7 past2",    1, 32'h0000_A000);
    step("R7 below3",   1, 32'h0000_FFFF);
    step("R7 base3",    1, 32'h0001_0000);
    step("R7 lim3",     1, 32'h0001_FFE0);
    step("R7 past3",    1, 32'h0002_0000);
    // R8 overlap: seg1 beats seg2 in 0x6000-0x7FFF
    step("R8 overlap lo", 1, 32'h0000_6000);
    step("R8 overlap hi", 1, 32'h0000_7FE0);
    step("R8 seg2 only",  1, 32'h0000_8000);
    // R9 unmapped
    step("R9 top",      1, 32'hFFFF_FFFF);
    step("R9 hole",     1, 32'h0000_C000);
    // R10 / R11 valid gap
    step("R11 gap",     0, 32'h0000_8000);
    step("R10 resume",  1, 32'h0000_5000);
    // R6 same id over a segment
    step("R6 seg3 a",   1, 32'h0001_2340);
    step("R6 seg3 b",   1, 32'h0001_ABCD);
    for (int n = 0; n < 3000; n++) begin
      int unsigned a;
      a = $urandom % 32'h2_4000;
      step("rand", ($urandom % 4) != 0, a);
    end
    step("R11 end", 0, 0);
    @(negedge clk);
    check_all(cur_tag);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule